// File: doc/BRIEF.md
# Privileged System Register Access Gate

This block holds one 64-bit hypervisor trap-control register and decides, for every system-register instruction that reaches it, what happens to the access. The decision depends on three things: the five-field encoding of the instruction, the privilege level it runs at, and three virtualisation controls. The possible outcomes are:

- the encoding does not name this register, and the request is not handled;
- the access is undefined;
- the access traps to the hypervisor with a fixed exception class;
- the access is redirected to a memory slot at a fixed offset;
- the register is read or written directly.

The result appears on a registered response one cycle after the request. The surrounding pipeline turns this response into an exception entry or a memory access, and those parts live outside this block. For a redirected read, the memory subsystem supplies the data.

The register keeps only its sixteen low control bits, less two that are reserved. Every other bit reads as zero. The reset value of the register is a simulation convenience only, and users must not rely on it.

Top module: `sysreg_gate`

## Requirements
- R1: A request whose encoding is not op0=2'b11, op1=3'b100, CRn=4'b0001, CRm=4'b0001, op2=3'b011 gets a response with rsp_hit=0, all outcome flags low, rsp_rdata=0 and rsp_redir_wdata=0, and it leaves the register unchanged.
- R2: A matching request at privilege level 0 responds with rsp_undef=1, whatever the virtualisation controls are.
- R3: A matching request at level 1 with hyp_en=1, nv2=1 and nv=1 responds with rsp_redir=1 and rsp_redir_off=12'h080. It also sets rsp_redir_wr equal to the request's write flag. On a redirected write, rsp_redir_wdata carries the write data; otherwise it is zero.
- R4: A matching request at level 1 with hyp_en=1, nv=1 and nv2=0 responds with rsp_trap=1 and rsp_ec=6'h18.
- R5: A matching request at level 1 that meets neither the R3 nor the R4 condition responds with rsp_undef=1.
- R6: A matching request at level 2 or 3 writes the register (req_write=1) or returns its value on rsp_rdata (req_write=0). A read that follows a write returns the written value.
- R7: Bits 63:16, bit 14 and bit 4 of the register read as zero, whatever value was written.
- R8: Each request is answered by a single-cycle rsp_valid pulse one cycle later, and no cycle without a request produces one. Each response raises at most one of rsp_undef, rsp_trap and rsp_redir, and none of them unless rsp_hit=1.
- R9: Undefined, trapped and redirected writes leave the register unchanged. rsp_rdata is zero for every response that is not a direct read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_priv | input | 2 | Current privilege level 0..3 |
| hyp_en | input | 1 | Hypervisor enabled in the current state |
| nv2 | input | 1 | Second nested-virtualisation control |
| nv | input | 1 | First nested-virtualisation control |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response pulse, one cycle after a request |
| rsp_hit | output | 1 | Encoding named this register |
| rsp_rdata | output | 64 | Direct read data |
| rsp_undef | output | 1 | Access is undefined |
| rsp_trap | output | 1 | Access traps to the hypervisor |
| rsp_ec | output | 6 | Exception class for a trap |
| rsp_redir | output | 1 | Access redirected to memory |
| rsp_redir_wr | output | 1 | Redirected access is a write |
| rsp_redir_off | output | 12 | Memory slot offset |
| rsp_redir_wdata | output | 64 | Data for a redirected write |

## Verification
The assertions assume that reset is held low for at least one clock edge, and that requests are only presented while reset is high. The bench keeps req_valid low throughout reset. The assertions also assume that the inputs are stable from one falling edge to the next. The bench meets this by changing every request input only on falling edges, one request per cycle, with idle gaps mixed in. Because the reset value of the register is not defined, the bench reads the register only after it has written it, so every expected read value comes from a write the bench made.

// File: rtl/sysreg_gate_pkg.sv
// Package: shared outcome type and the fixed constants of the access gate.
// Assumes: a single register at a single encoding; constants are not
// changed per instance.
package sysreg_gate_pkg;

    // Outcome chosen for one request
    typedef enum logic [2:0] {
        ACT_NONE   = 3'd0,
        ACT_UNDEF  = 3'd1,
        ACT_TRAP   = 3'd2,
        ACT_REDIR  = 3'd3,
        ACT_DIRECT = 3'd4
    } act_e;

    // Encoding that selects the register
    localparam logic [1:0] ENC_OP0 = 2'b11;
    localparam logic [2:0] ENC_OP1 = 3'b100;
    localparam logic [3:0] ENC_CRN = 4'b0001;
    localparam logic [3:0] ENC_CRM = 4'b0001;
    localparam logic [2:0] ENC_OP2 = 3'b011;

    // Low control bits kept by the register (bits 14 and 4 reserved)
    localparam int          CTL_BITS = 16;
    localparam logic [15:0] CTL_KEEP = 16'hBFEF;

endpackage

// File: rtl/sr_match.sv
// Module: sr_match
// Compares the five encoding fields of a request with one fixed encoding.
// Assumes: fields are stable while req is sampled; purely combinational.
module sr_match #(
    parameter int          OP0_W = 2,
    parameter int          OP1_W = 3,
    parameter int          CR_W  = 4,
    parameter int          OP2_W = 3,
    parameter logic [1:0]  K_OP0 = 2'b11,
    parameter logic [2:0]  K_OP1 = 3'b100,
    parameter logic [3:0]  K_CRN = 4'b0001,
    parameter logic [3:0]  K_CRM = 4'b0001,
    parameter logic [2:0]  K_OP2 = 3'b011
) (
    input  logic [OP0_W-1:0] op0,
    input  logic [OP1_W-1:0] op1,
    input  logic [CR_W-1:0]  crn,
    input  logic [CR_W-1:0]  crm,
    input  logic [OP2_W-1:0] op2,
    output logic             hit
);
    // Full-field equality against the selected encoding
    always_comb begin
        hit = (op0 == K_OP0) && (op1 == K_OP1) && (crn == K_CRN) &&
              (crm == K_CRM) && (op2 == K_OP2);
    end
endmodule

// File: rtl/sr_policy.sv
// Module: sr_policy
// Chooses the outcome of a request from the encoding hit, the privilege
// level and the virtualisation controls.
// Assumes: priv is 0..3; combinational, no state.
module sr_policy
    import sysreg_gate_pkg::*;
#(
    parameter int PRIV_W = 2
) (
    input  logic              hit,
    input  logic [PRIV_W-1:0] priv,
    input  logic              hyp_en,
    input  logic              nv2,
    input  logic              nv,
    output act_e              act
);
    localparam logic [PRIV_W-1:0] LVL_USER = PRIV_W'(0);
    localparam logic [PRIV_W-1:0] LVL_KERN = PRIV_W'(1);

    // Priority: miss, user level, kernel level controls, upper levels
    always_comb begin
        if (!hit) begin
            act = ACT_NONE;
        end else if (priv == LVL_USER) begin
            act = ACT_UNDEF;
        end else if (priv == LVL_KERN) begin
            if (hyp_en && nv && nv2)
                act = ACT_REDIR;
            else if (hyp_en && nv)
                act = ACT_TRAP;
            else
                act = ACT_UNDEF;
        end else begin
            act = ACT_DIRECT;
        end
    end
endmodule

// File: rtl/sr_ctl_reg.sv
// Module: sr_ctl_reg
// Holds the trap-control register; only bits set in KEEP are stored.
// Assumes: reset value is a model convenience, not a defined value.
module sr_ctl_reg #(
    parameter int               DATA_W = 64,
    parameter logic [DATA_W-1:0] KEEP  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    // Per-bit storage; reserved bits become constant zero
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (KEEP[b]) begin : g_kept
            logic bit_q;
            // Store one writable control bit
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bit_q <= 1'b0;
                else if (we)
                    bit_q <= wdata[b];
            end
            assign q[b] = bit_q;
        end else begin : g_rsvd
            assign q[b] = 1'b0;
        end
    end
endmodule

// File: rtl/sysreg_gate.sv
// Module: sysreg_gate (top)
// Gates system-register instructions to the trap-control register by
// privilege level and registers a one-cycle-late response.
// Assumes: at most one request per cycle; memory and exception entry are
// handled by the consumer of the response.
module sysreg_gate
    import sysreg_gate_pkg::*;
#(
    parameter int          DATA_W    = 64,
    parameter int          PRIV_W    = 2,
    parameter int          EC_W      = 6,
    parameter int          OFF_W     = 12,
    parameter logic [5:0]  TRAP_EC   = 6'h18,
    parameter logic [11:0] REDIR_OFF = 12'h080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_op0,
    input  logic [2:0]        req_op1,
    input  logic [3:0]        req_crn,
    input  logic [3:0]        req_crm,
    input  logic [2:0]        req_op2,
    input  logic [PRIV_W-1:0] req_priv,
    input  logic              hyp_en,
    input  logic              nv2,
    input  logic              nv,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_undef,
    output logic              rsp_trap,
    output logic [EC_W-1:0]   rsp_ec,
    output logic              rsp_redir,
    output logic              rsp_redir_wr,
    output logic [OFF_W-1:0]  rsp_redir_off,
    output logic [DATA_W-1:0] rsp_redir_wdata
);
    localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'(CTL_KEEP);
    localparam logic [EC_W-1:0]   EC_VAL    = EC_W'(TRAP_EC);
    localparam logic [OFF_W-1:0]  OFF_VAL   = OFF_W'(REDIR_OFF);

    logic              enc_hit;
    act_e              act;
    logic              ctl_we;
    logic [DATA_W-1:0] ctl_q;

    sr_match u_match (
        .op0 (req_op0),
        .op1 (req_op1),
        .crn (req_crn),
        .crm (req_crm),
        .op2 (req_op2),
        .hit (enc_hit)
    );

    sr_policy #(.PRIV_W(PRIV_W)) u_policy (
        .hit    (enc_hit),
        .priv   (req_priv),
        .hyp_en (hyp_en),
        .nv2    (nv2),
        .nv     (nv),
        .act    (act)
    );

    // Direct writes only reach the register
    always_comb begin
        ctl_we = req_valid && req_write && (act == ACT_DIRECT);
    end

    sr_ctl_reg #(.DATA_W(DATA_W), .KEEP(KEEP_MASK)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .wdata (req_wdata),
        .q     (ctl_q)
    );

    // Register the response fields one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid       <= 1'b0;
            rsp_hit         <= 1'b0;
            rsp_rdata       <= '0;
            rsp_undef       <= 1'b0;
            rsp_trap        <= 1'b0;
            rsp_ec          <= '0;
            rsp_redir       <= 1'b0;
            rsp_redir_wr    <= 1'b0;
            rsp_redir_off   <= '0;
            rsp_redir_wdata <= '0;
        end else begin
            rsp_valid       <= req_valid;
            rsp_hit         <= req_valid && (act != ACT_NONE);
            rsp_rdata       <= (req_valid && !req_write && act == ACT_DIRECT) ? ctl_q : '0;
            rsp_undef       <= req_valid && (act == ACT_UNDEF);
            rsp_trap        <= req_valid && (act == ACT_TRAP);
            rsp_ec          <= (req_valid && act == ACT_TRAP) ? EC_VAL : '0;
            rsp_redir       <= req_valid && (act == ACT_REDIR);
            rsp_redir_wr    <= req_valid && (act == ACT_REDIR) && req_write;
            rsp_redir_off   <= (req_valid && act == ACT_REDIR) ? OFF_VAL : '0;
            rsp_redir_wdata <= (req_valid && act == ACT_REDIR && req_write) ? req_wdata : '0;
        end
    end

    // Checks on the response path
    assert_rsp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_single_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot0({rsp_undef, rsp_trap, rsp_redir}));
    assert_miss_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !enc_hit) |=> (!rsp_hit && !rsp_undef && !rsp_trap && !rsp_redir));
    assert_user_undef_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && enc_hit && req_priv == '0) |=> rsp_undef);
    assert_redir_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_redir |-> (rsp_redir_off == OFF_VAL));
    assert_trap_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |-> (rsp_ec == EC_VAL));
    assert_kern_undef_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && enc_hit && req_priv == PRIV_W'(1) && !(hyp_en && nv)) |=> rsp_undef);
    assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_rdata & ~KEEP_MASK) == '0));
    assert_low_priv_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_priv < PRIV_W'(2)) |=> $stable(ctl_q));
endmodule

// File: tb/test_sysreg_gate.sv
module test_sysreg_gate;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [63:0] KEEP = 64'h0000_0000_0000_BFEF;

    typedef struct {
        int          cyc;
        logic        hit;
        logic [63:0] rdata;
        logic        undef;
        logic        trap;
        logic [5:0]  ec;
        logic        redir;
        logic        redir_wr;
        logic [11:0] off;
        logic [63:0] wdat;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_op0 = '0;
    logic [2:0]  req_op1 = '0;
    logic [3:0]  req_crn = '0, req_crm = '0;
    logic [2:0]  req_op2 = '0;
    logic [1:0]  req_priv = '0;
    logic        hyp_en = 1'b0, nv2 = 1'b0, nv = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid, rsp_hit, rsp_undef, rsp_trap, rsp_redir, rsp_redir_wr;
    logic [63:0] rsp_rdata, rsp_redir_wdata;
    logic [5:0]  rsp_ec;
    logic [11:0] rsp_redir_off;

    exp_t  q[$];
    string tags[$];
    logic [63:0] model_reg = '0;
    int cyc = 0, checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sysreg_gate i_sysreg_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
        .req_op2(req_op2), .req_priv(req_priv), .hyp_en(hyp_en), .nv2(nv2), .nv(nv),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_rdata(rsp_rdata), .rsp_undef(rsp_undef), .rsp_trap(rsp_trap),
        .rsp_ec(rsp_ec), .rsp_redir(rsp_redir), .rsp_redir_wr(rsp_redir_wr),
        .rsp_redir_off(rsp_redir_off), .rsp_redir_wdata(rsp_redir_wdata)
    );

    // Driver: one request per falling edge, expected result pushed to the queue
    task automatic issue(input bit wr, input bit match, input logic [1:0] pr,
                         input bit hy, input bit n2, input bit n1,
                         input logic [63:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr;
        req_op0 = 2'b11; req_op1 = 3'b100; req_crn = 4'b0001; req_crm = 4'b0001;
        req_op2 = match ? 3'b011 : 3'b010;
        req_priv = pr; hyp_en = hy; nv2 = n2; nv = n1; req_wdata = d;
        e = '{cyc: cyc, hit: match, rdata: '0, undef: 0, trap: 0, ec: '0,
              redir: 0, redir_wr: 0, off: '0, wdat: '0};
        if (match) begin
            if (pr == 2'd0) e.undef = 1;
            else if (pr == 2'd1) begin
                if (hy && n1 && n2) begin
                    e.redir = 1; e.redir_wr = wr; e.off = 12'h080;
                    if (wr) e.wdat = d;
                end else if (hy && n1) begin
                    e.trap = 1; e.ec = 6'h18;
                end else e.undef = 1;
            end else begin
                if (wr) model_reg = d & KEEP;
                else e.rdata = model_reg;
            end
        end
        q.push_back(e);
        tags.push_back(tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    // Monitor: pops and compares responses; flags unexpected pulses
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (q.size() > 0 && q[0].cyc + 1 == cyc) begin
                exp_t e;
                string t;
                e = q.pop_front();
                t = tags.pop_front();
                checks++;
                if (!rsp_valid || rsp_hit !== e.hit || rsp_rdata !== e.rdata ||
                    rsp_undef !== e.undef || rsp_trap !== e.trap || rsp_ec !== e.ec ||
                    rsp_redir !== e.redir || rsp_redir_wr !== e.redir_wr ||
                    rsp_redir_off !== e.off || rsp_redir_wdata !== e.wdat) begin
                    errors++;
                    $display("FAIL %s: got v=%b h=%b rd=%h u=%b t=%b ec=%h r=%b rw=%b off=%h wd=%h exp v=1 h=%b rd=%h u=%b t=%b ec=%h r=%b rw=%b off=%h wd=%h",
                        t, rsp_valid, rsp_hit, rsp_rdata, rsp_undef, rsp_trap, rsp_ec,
                        rsp_redir, rsp_redir_wr, rsp_redir_off, rsp_redir_wdata,
                        e.hit, e.rdata, e.undef, e.trap, e.ec, e.redir, e.redir_wr,
                        e.off, e.wdat);
                end
            end else if (rsp_valid) begin
                checks++; errors++;
                $display("FAIL R8: unexpected rsp_valid=1, expected 0");
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R8: watchdog expired, got no end, expected end");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        checks++;
        if (rsp_valid !== 1'b0 || rsp_undef !== 1'b0 || rsp_trap !== 1'b0 || rsp_redir !== 1'b0) begin
            errors++;
            $display("FAIL R8: reset outputs v=%b u=%b t=%b r=%b, expected all 0",
                     rsp_valid, rsp_undef, rsp_trap, rsp_redir);
        end
        rst_n = 1'b1;
        // R6 R7: direct write/read at upper levels
        issue(1, 1, 2'd2, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
        issue(0, 1, 2'd2, 0, 0, 0, '0, "R7");
        issue(1, 1, 2'd3, 1, 1, 1, 64'h1234_5678_9ABC_DEF0, "R6");
        issue(0, 1, 2'd3, 0, 0, 0, '0, "R6");
        issue(0, 1, 2'd2, 1, 0, 1, '0, "R6");
        // R2: level 0 undefined
        issue(0, 1, 2'd0, 1, 1, 1, '0, "R2");
        issue(1, 1, 2'd0, 1, 0, 1, 64'hFFFF, "R2");
        issue(0, 1, 2'd2, 0, 0, 0, '0, "R9");
        // R3: redirect
        issue(1, 1, 2'd1, 1, 1, 1, 64'hA5A5_0000_0000_5A5A, "R3");
        issue(0, 1, 2'd1, 1, 1, 1, '0, "R3");
        issue(0, 1, 2'd3, 0, 0, 0, '0, "R9");
        // R4: trap
        issue(1, 1, 2'd1, 1, 0, 1, 64'h0000_0000_0000_0001, "R4");
        issue(0, 1, 2'd1, 1, 0, 1, '0, "R4");
        // R5: other level 1 cases
        issue(1, 1, 2'd1, 0, 1, 1, 64'h0000_0000_0000_0002, "R5");
        issue(0, 1, 2'd1, 1, 1, 0, '0, "R5");
        issue(0, 1, 2'd1, 0, 0, 0, '0, "R5");
        issue(0, 1, 2'd2, 0, 0, 0, '0, "R9");
        // R1: encoding mismatch
        issue(1, 0, 2'd2, 0, 0, 0, 64'h0000_0000_0000_0000, "R1");
        issue(0, 0, 2'd3, 1, 1, 1, '0, "R1");
        issue(0, 1, 2'd2, 0, 0, 0, '0, "R1");
        // R8: gap then back-to-back sweep of every level and control
        idle(4);
        issue(1, 1, 2'd2, 0, 0, 0, 64'h0000_0000_0000_4010, "R7");
        issue(0, 1, 2'd2, 0, 0, 0, '0, "R7");
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 8; c++) begin
                issue(c[0], 1, 2'(p), c[2], c[1], c[0], 64'h0000_0000_0000_3C3C, "R8");
            end
        end
        issue(0, 1, 2'd3, 0, 0, 0, '0, "R6");
        idle(3);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule